// File: doc/BRIEF.md
# Segmented Address Generation Unit

This block turns a 16-bit offset and a reference kind into a 20-bit physical byte address. It holds four 16-bit segment bases: code, stack, data and extra. It picks one of them by fixed rules. The result is the chosen base shifted up by four bits plus the offset, kept to 20 bits. A separate write port loads the segment bases.

Each request is taken in a single cycle while the unit is idle. The unit then runs byte-wide bus cycles that follow a request/acknowledge rule. A byte operand uses one bus cycle. A 16-bit operand, at either an even or an odd offset, uses two bus cycles: the low byte comes first, at the offset, and the high byte follows at the offset plus one within the same segment. When the last cycle is acknowledged, a one-cycle `done` pulse appears. Read bytes are collected into a 16-bit result.

Top module: `segAddrGen`

## Requirements
- R1: After reset, `busReq`, `done` and `busy` are 0, `rdData` is 0, and all four segment bases are 0.
- R2: The bus address equals (segment × 16 + offset) modulo 2^20. For example, base FFFFh with offset 0020h gives 00010h.
- R3: A fetch (`refType` = 0) always uses the code base (`segWrSel` = 0). The override inputs have no effect on it.
- R4: A stack reference (`refType` = 1) always uses the stack base (`segWrSel` = 1). The override inputs have no effect on it.
- R5: A string destination (`refType` = 3) always uses the extra base (`segWrSel` = 3). The override inputs have no effect on it.
- R6: For a data reference (`refType` = 2), the base is chosen by the first matching rule: if `ovrEn` is set, the base named by `ovrSel`; otherwise, if `bpRel` is set, the stack base; otherwise the data base.
- R7: A byte access makes exactly one bus cycle. `done` goes high for one cycle, in the cycle after the acknowledge. `rdData` is {8'h00, the byte read}.
- R8: A word access makes two bus cycles. The first is at the offset. The second is at (offset + 1) modulo 2^16 in the same segment, so offset FFFFh continues at offset 0000h.
- R9: On a word read, `done` rises only after the second acknowledge. `rdData` holds the first byte in bits 7:0 and the second byte in bits 15:8.
- R10: `busWrite` follows the request's write flag. `busWData` carries `wrData[7:0]` on the first cycle and `wrData[15:8]` on the second.
- R11: While `busReq` is high and no acknowledge has arrived, `busReq`, `busAddr` and `busWData` hold their values.
- R12: `reqValid` is ignored while `busy` is high. A new bus cycle starts only from a request accepted while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| segWrEn | input | 1 | Load the segment base picked by segWrSel |
| segWrSel | input | 2 | 0 code, 1 stack, 2 data, 3 extra |
| segWrData | input | 16 | New segment base value |
| reqValid | input | 1 | Request strobe, taken when idle |
| refType | input | 2 | 0 fetch, 1 stack, 2 data, 3 string destination |
| bpRel | input | 1 | Data reference is based on the base pointer |
| ovrEn | input | 1 | Explicit segment override present |
| ovrSel | input | 2 | Override segment, same coding as segWrSel |
| isWrite | input | 1 | 1 write, 0 read |
| isWord | input | 1 | 1 word (two bytes), 0 byte |
| offset | input | 16 | Offset within the segment |
| wrData | input | 16 | Write operand |
| busAck | input | 1 | Bus cycle acknowledge |
| busRData | input | 8 | Read byte, valid with busAck |
| busy | output | 1 | Request in progress |
| busReq | output | 1 | Byte bus cycle request |
| busAddr | output | 20 | Physical byte address |
| busWrite | output | 1 | Bus cycle direction |
| busWData | output | 8 | Write byte |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Assembled read data |

## Verification
Two situations are the hardest to reach from the ports. The first is a word whose offset is FFFFh, where the second byte must wrap back to the bottom of the same segment and must not step into the next 64K window. The bench loads a data base and issues a word read at that offset. The second is a base near the top of memory, where the 20-bit sum itself overflows; a base of FFFFh drives that case. A stray `reqValid` during a stalled word cycle is produced by holding `busAck` low for several cycles while the bench pulses a request with a different offset.

// File: rtl/segAddrPkg.sv
package segAddrPkg;
  // reference kinds
  localparam logic [1:0] REF_FETCH  = 2'd0;
  localparam logic [1:0] REF_STACK  = 2'd1;
  localparam logic [1:0] REF_DATA   = 2'd2;
  localparam logic [1:0] REF_STRDST = 2'd3;
  // segment register indices
  localparam logic [1:0] SEG_CODE  = 2'd0;
  localparam logic [1:0] SEG_STACK = 2'd1;
  localparam logic [1:0] SEG_DATA  = 2'd2;
  localparam logic [1:0] SEG_EXTRA = 2'd3;

  typedef enum logic [1:0] {ST_IDLE, ST_LO, ST_HI, ST_FIN} seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic capLo;
    logic capHi;
    logic hiPhase;
  } pathCtl_t;
endpackage

// File: rtl/segAddrCtrl.sv
module segAddrCtrl
  import segAddrPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     reqValid,
  input  logic     busAck,
  input  logic     reqWord,
  output pathCtl_t ctl,
  output logic     busReq,
  output logic     done,
  output logic     busy
);
  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    case (state)
      ST_IDLE: if (reqValid) nextState = ST_LO;
      ST_LO:   if (busAck) nextState = reqWord ? ST_HI : ST_FIN;
      ST_HI:   if (busAck) nextState = ST_FIN;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    ctl.accept  = (state == ST_IDLE) && reqValid;
    ctl.capLo   = (state == ST_LO) && busAck;
    ctl.capHi   = (state == ST_HI) && busAck;
    ctl.hiPhase = (state == ST_HI);
  end

  assign busReq = (state == ST_LO) || (state == ST_HI);
  assign done   = (state == ST_FIN);
  assign busy   = (state != ST_IDLE);
endmodule

// File: rtl/segAddrPath.sv
module segAddrPath
  import segAddrPkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 4,
  parameter int BYTE_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  pathCtl_t               ctl,
  input  logic                   segWrEn,
  input  logic [1:0]             segWrSel,
  input  logic [OFF_W-1:0]       segWrData,
  input  logic [1:0]             refType,
  input  logic                   bpRel,
  input  logic                   ovrEn,
  input  logic [1:0]             ovrSel,
  input  logic                   isWrite,
  input  logic                   isWord,
  input  logic [OFF_W-1:0]       offset,
  input  logic [2*BYTE_W-1:0]    wrData,
  input  logic [BYTE_W-1:0]      busRData,
  output logic [OFF_W+SHIFT-1:0] busAddr,
  output logic                   busWrite,
  output logic [BYTE_W-1:0]      busWData,
  output logic [2*BYTE_W-1:0]    rdData,
  output logic                   reqWord
);
  localparam int ADDR_W = OFF_W + SHIFT;
  localparam int WORD_W = 2 * BYTE_W;

  logic [OFF_W-1:0]  segFile [NUM_SEG];
  logic [OFF_W-1:0]  segVal, offReg, curOff;
  logic [WORD_W-1:0] wrReg;
  logic              writeReg;
  logic [1:0]        pick;

  // base selection rules by reference kind
  always_comb begin
    case (refType)
      REF_FETCH:  pick = SEG_CODE;
      REF_STACK:  pick = SEG_STACK;
      REF_STRDST: pick = SEG_EXTRA;
      default:    pick = ovrEn ? ovrSel : (bpRel ? SEG_STACK : SEG_DATA);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) segFile[i] <= '0;
    end else if (segWrEn) begin
      segFile[segWrSel] <= segWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      segVal   <= '0;
      offReg   <= '0;
      wrReg    <= '0;
      writeReg <= 1'b0;
      reqWord  <= 1'b0;
    end else if (ctl.accept) begin
      segVal   <= segFile[pick];
      offReg   <= offset;
      wrReg    <= wrData;
      writeReg <= isWrite;
      reqWord  <= isWord;
    end
  end

  // offset steps within the segment before the base is added
  assign curOff   = ctl.hiPhase ? offReg + OFF_W'(1) : offReg;
  assign busAddr  = {segVal, {SHIFT{1'b0}}} + ADDR_W'(curOff);
  assign busWrite = writeReg;
  assign busWData = ctl.hiPhase ? wrReg[WORD_W-1:BYTE_W] : wrReg[BYTE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (ctl.capLo) begin
      rdData <= {{BYTE_W{1'b0}}, busRData};
    end else if (ctl.capHi) begin
      rdData[WORD_W-1:BYTE_W] <= busRData;
    end
  end
endmodule

// File: rtl/segAddrGen.sv
module segAddrGen
  import segAddrPkg::*;
#(
  parameter int OFF_W   = 16,
  parameter int SHIFT   = 4,
  parameter int NUM_SEG = 4,
  parameter int BYTE_W  = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   segWrEn,
  input  logic [1:0]             segWrSel,
  input  logic [OFF_W-1:0]       segWrData,
  input  logic                   reqValid,
  input  logic [1:0]             refType,
  input  logic                   bpRel,
  input  logic                   ovrEn,
  input  logic [1:0]             ovrSel,
  input  logic                   isWrite,
  input  logic                   isWord,
  input  logic [OFF_W-1:0]       offset,
  input  logic [2*BYTE_W-1:0]    wrData,
  input  logic                   busAck,
  input  logic [BYTE_W-1:0]      busRData,
  output logic                   busy,
  output logic                   busReq,
  output logic [OFF_W+SHIFT-1:0] busAddr,
  output logic                   busWrite,
  output logic [BYTE_W-1:0]      busWData,
  output logic                   done,
  output logic [2*BYTE_W-1:0]    rdData
);
  pathCtl_t ctl;
  logic     reqWord;

  segAddrCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .busAck(busAck),
    .reqWord(reqWord), .ctl(ctl), .busReq(busReq), .done(done), .busy(busy)
  );

  segAddrPath #(.OFF_W(OFF_W), .SHIFT(SHIFT), .NUM_SEG(NUM_SEG), .BYTE_W(BYTE_W)) u_path (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .segWrEn(segWrEn), .segWrSel(segWrSel), .segWrData(segWrData),
    .refType(refType), .bpRel(bpRel), .ovrEn(ovrEn), .ovrSel(ovrSel),
    .isWrite(isWrite), .isWord(isWord), .offset(offset), .wrData(wrData),
    .busRData(busRData), .busAddr(busAddr), .busWrite(busWrite),
    .busWData(busWData), .rdData(rdData), .reqWord(reqWord)
  );
endmodule

// File: rtl/segAddrChk.sv
module segAddrChk #(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              busAck,
  input logic              busy,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic [BYTE_W-1:0] busWData,
  input logic              done
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq && $stable(busAddr) && $stable(busWData)); // R11

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R7

  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busReq && busAck) && !busReq); // R9

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(reqValid) && !$past(busy)); // R12

  AST_SECOND_BYTE_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    busReq && $past(busReq && busAck) |-> busAddr[3:0] == $past(busAddr[3:0]) + 4'd1); // R8
endmodule

bind segAddrGen segAddrChk #(.ADDR_W(OFF_W + SHIFT), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .busAck(busAck), .busy(busy),
  .busReq(busReq), .busAddr(busAddr), .busWData(busWData), .done(done)
);

// File: tb/segAddrGen_bench.sv
module segAddrGen_bench;
  logic        clk = 1'b0;
  logic        rstN;
  logic        segWrEn;
  logic [1:0]  segWrSel;
  logic [15:0] segWrData;
  logic        reqValid;
  logic [1:0]  refType;
  logic        bpRel, ovrEn;
  logic [1:0]  ovrSel;
  logic        isWrite, isWord;
  logic [15:0] offset, wrData;
  logic        busAck;
  logic [7:0]  busRData;
  logic        busy, busReq, busWrite, done;
  logic [19:0] busAddr;
  logic [7:0]  busWData;
  logic [15:0] rdData;

  int checks = 0;
  int fails  = 0;

  logic [19:0] gotAddr [2];
  logic [7:0]  gotWd [2];
  logic        gotWr;
  logic [15:0] gotRd;

  always #5 clk = ~clk;

  segAddrGen u_segAddrGen (
    .clk(clk), .rstN(rstN), .segWrEn(segWrEn), .segWrSel(segWrSel),
    .segWrData(segWrData), .reqValid(reqValid), .refType(refType),
    .bpRel(bpRel), .ovrEn(ovrEn), .ovrSel(ovrSel), .isWrite(isWrite),
    .isWord(isWord), .offset(offset), .wrData(wrData), .busAck(busAck),
    .busRData(busRData), .busy(busy), .busReq(busReq), .busAddr(busAddr),
    .busWrite(busWrite), .busWData(busWData), .done(done), .rdData(rdData)
  );

  function automatic logic [19:0] phys(input logic [15:0] seg, input logic [15:0] off);
    logic [23:0] sum;
    sum = {4'h0, seg, 4'h0} + {8'h00, off};
    return sum[19:0];
  endfunction

  function automatic logic [7:0] memByte(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic loadSeg(input logic [1:0] sel, input logic [15:0] val);
    @(negedge clk);
    segWrEn = 1'b1; segWrSel = sel; segWrData = val;
    @(negedge clk);
    segWrEn = 1'b0;
  endtask

  // issue one request, act as the bus, and record what came out
  task automatic doAccess(input logic [1:0] rt, input logic bp, input logic oe,
                          input logic [1:0] os, input logic wr, input logic wd,
                          input logic [15:0] off, input logic [15:0] data,
                          input int waits, input bit poke);
    logic [19:0] held;
    @(negedge clk);
    refType = rt; bpRel = bp; ovrEn = oe; ovrSel = os;
    isWrite = wr; isWord = wd; offset = off; wrData = data; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    for (int b = 0; b < (wd ? 2 : 1); b++) begin
      held = busAddr;
      for (int w = 0; w < waits; w++) begin
        if (poke) begin reqValid = 1'b1; offset = off ^ 16'h5A5A; end
        @(negedge clk);
        reqValid = 1'b0;
        chkEq("R11 busReq held", {31'd0, busReq}, 32'd1);
        chkEq("R11 address held", {12'd0, busAddr}, {12'd0, held});
      end
      chkEq("R7 busReq during cycle", {31'd0, busReq}, 32'd1);
      gotAddr[b] = busAddr;
      gotWd[b]   = busWData;
      gotWr      = busWrite;
      busRData   = memByte(busAddr);
      busAck     = 1'b1;
      @(negedge clk);
      busAck = 1'b0;
      if (wd && b == 0) begin
        chkEq("R9 no done after first byte", {31'd0, done}, 32'd0);
        chkEq("R8 second cycle requested", {31'd0, busReq}, 32'd1);
      end else begin
        chkEq("R7 done after last ack", {31'd0, done}, 32'd1);
        chkEq("R7 no further request", {31'd0, busReq}, 32'd0);
      end
    end
    gotRd = rdData;
    @(negedge clk);
    chkEq("R7 done lasts one cycle", {31'd0, done}, 32'd0);
    chkEq("R12 idle after completion", {30'd0, busy, busReq}, 32'd0);
  endtask

  task automatic testReset;
    chkEq("R1 busReq after reset", {31'd0, busReq}, 32'd0);
    chkEq("R1 done after reset", {31'd0, done}, 32'd0);
    chkEq("R1 busy after reset", {31'd0, busy}, 32'd0);
    chkEq("R1 rdData after reset", {16'd0, rdData}, 32'd0);
    doAccess(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h1234, 16'h0, 0, 1'b0);
    chkEq("R1 zero base gives bare offset", {12'd0, gotAddr[0]}, 32'h01234);
  endtask

  task automatic testFixedKinds;
    doAccess(2'd0, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 16'h0010, 16'h0, 0, 1'b0);
    chkEq("R3 fetch ignores override", {12'd0, gotAddr[0]}, {12'd0, phys(16'h1000, 16'h0010)});
    doAccess(2'd1, 1'b0, 1'b1, 2'd3, 1'b0, 1'b0, 16'h0020, 16'h0, 0, 1'b0);
    chkEq("R4 stack ignores override", {12'd0, gotAddr[0]}, {12'd0, phys(16'h2000, 16'h0020)});
    doAccess(2'd3, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 16'h0030, 16'h0, 0, 1'b0);
    chkEq("R5 string dest ignores override", {12'd0, gotAddr[0]}, {12'd0, phys(16'h4000, 16'h0030)});
  endtask

  task automatic testDataRules;
    doAccess(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0040, 16'h0, 0, 1'b0);
    chkEq("R6 plain data uses data base", {12'd0, gotAddr[0]}, {12'd0, phys(16'h3000, 16'h0040)});
    doAccess(2'd2, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0050, 16'h0, 0, 1'b0);
    chkEq("R6 bp-relative uses stack base", {12'd0, gotAddr[0]}, {12'd0, phys(16'h2000, 16'h0050)});
    doAccess(2'd2, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 16'h0060, 16'h0, 0, 1'b0);
    chkEq("R6 override beats bp-relative", {12'd0, gotAddr[0]}, {12'd0, phys(16'h4000, 16'h0060)});
    doAccess(2'd2, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 16'h0070, 16'h0, 0, 1'b0);
    chkEq("R6 override to code base", {12'd0, gotAddr[0]}, {12'd0, phys(16'h1000, 16'h0070)});
  endtask

  task automatic testWrap;
    loadSeg(2'd3, 16'hFFFF);
    doAccess(2'd3, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0020, 16'h0, 0, 1'b0);
    chkEq("R2 20-bit wrap", {12'd0, gotAddr[0]}, 32'h00010);
    loadSeg(2'd3, 16'h4000);
  endtask

  task automatic testByteRead;
    doAccess(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0ABC, 16'h0, 1, 1'b0);
    chkEq("R2 byte address", {12'd0, gotAddr[0]}, {12'd0, phys(16'h3000, 16'h0ABC)});
    chkEq("R7 byte read data", {16'd0, gotRd}, {24'd0, memByte(phys(16'h3000, 16'h0ABC))});
    chkEq("R10 read direction", {31'd0, gotWr}, 32'd0);
  endtask

  task automatic testWordOdd;
    logic [19:0] a0, a1;
    a0 = phys(16'h3000, 16'h0101);
    a1 = phys(16'h3000, 16'h0102);
    doAccess(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 16'h0101, 16'h0, 2, 1'b1);
    chkEq("R8 low byte at offset", {12'd0, gotAddr[0]}, {12'd0, a0});
    chkEq("R8 high byte at offset+1", {12'd0, gotAddr[1]}, {12'd0, a1});
    chkEq("R9 assembled word", {16'd0, gotRd}, {16'd0, memByte(a1), memByte(a0)});
  endtask

  task automatic testWordSegEnd;
    doAccess(2'd2, 1'b0, 1'b0, 2'd0, 1'b0, 1'b1, 16'hFFFF, 16'h0, 0, 1'b0);
    chkEq("R8 offset FFFF low byte", {12'd0, gotAddr[0]}, 32'h3FFFF);
    chkEq("R8 offset wraps inside segment", {12'd0, gotAddr[1]}, 32'h30000);
  endtask

  task automatic testWordWrite;
    doAccess(2'd3, 1'b0, 1'b0, 2'd0, 1'b1, 1'b1, 16'h0200, 16'hBEEF, 1, 1'b0);
    chkEq("R10 write direction", {31'd0, gotWr}, 32'd1);
    chkEq("R10 low write byte", {24'd0, gotWd[0]}, 32'hEF);
    chkEq("R10 high write byte", {24'd0, gotWd[1]}, 32'hBE);
    chkEq("R5 write address", {12'd0, gotAddr[0]}, {12'd0, phys(16'h4000, 16'h0200)});
  endtask

  task automatic testIgnoreBusy;
    // stray requests were pulsed during the stalled word above; check again on a byte
    doAccess(2'd1, 1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 16'h0300, 16'h0, 3, 1'b1);
    chkEq("R12 address from first request", {12'd0, gotAddr[0]}, {12'd0, phys(16'h2000, 16'h0300)});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; segWrEn = 1'b0; segWrSel = '0; segWrData = '0; reqValid = 1'b0;
    refType = '0; bpRel = 1'b0; ovrEn = 1'b0; ovrSel = '0; isWrite = 1'b0;
    isWord = 1'b0; offset = '0; wrData = '0; busAck = 1'b0; busRData = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    loadSeg(2'd0, 16'h1000);
    loadSeg(2'd1, 16'h2000);
    loadSeg(2'd2, 16'h3000);
    loadSeg(2'd3, 16'h4000);
    testFixedKinds();
    testDataRules();
    testWrap();
    testByteRead();
    testWordOdd();
    testWordSegEnd();
    testWordWrite();
    testIgnoreBusy();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule